// File: doc/BRIEF.md
# Presence-Detect Configuration ROM with Two-Wire Slave Port

This block is a two-wire serial slave that holds a 256-byte presence-detect store. The store describes a memory module's configuration and timing. The lower half is loaded at reset with a fixed configuration table and cannot be changed from the bus. The upper half is free user storage. A host reaches the store by a 7-bit device address. That address has a fixed `1010` prefix and three board strap pins in its low bits.

A transaction starts by sending the device address. A write frame then carries a word address and any number of data bytes. A read returns bytes from an internal pointer. A random read sets the pointer with a write frame, then issues a repeated START and a read frame. The block watches its own checksum byte. After reset, and again after every accepted data byte, it sums bytes 0 to 62 and compares the low eight bits with byte 63. It reports the result on a status pin.

The serial lines are sampled by a faster system clock through synchronisers. The open-drain data line is modelled as a sensed input plus a pull-low enable.

Top module: `spd_rom`

## Requirements
- R1: While reset is held and right after it, `sda_oe_o` is 0. Within 80 system clocks after reset is released, `checksum_ok_o` is 1 for the default contents.
- R2: The block acknowledges a device-address byte by pulling SDA low in the ninth clock only when bits 7..1 equal `1010` followed by `strap_i[2:0]`. Bit 0 is 1 for read and 0 for write. On any other address it never drives SDA.
- R3: Data bytes written to word addresses 128..255 are stored and can be read back.
- R4: Data bytes sent to word addresses 0..127 are acknowledged. They leave the stored byte unchanged.
- R5: The reset contents of the lower half are as follows. Bytes 0..10 are 80h 08h 04h 0Bh 09h 01h 40h 00h 01h A0h 75h. Bytes 27..30 are 1Eh 14h 1Eh 32h. Byte 62 is 01h and byte 63 is 9Eh. A random read returns these values.
- R6: During a read, the pointer advances by one after each byte and wraps from 255 to 0.
- R7: A NACK from the master in the ninth clock of a read byte ends the transfer. SDA is released, and the next START is answered normally.
- R8: `checksum_ok_o` is 1 only when byte 63 equals the low 8 bits of the sum of bytes 0..62. It is 0 while a recomputation runs, which starts at reset and after each accepted data byte and lasts 63 system clocks.
- R9: The block changes its SDA drive only while SCL is low. Read data leaves most significant bit first.
- R10: In a write frame with several data bytes, the pointer advances after each byte and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 3 | Board strap bits forming the low device-address bits |
| scl_i | input | 1 | Serial clock as sensed on the bus |
| sda_i | input | 1 | Serial data as sensed on the bus |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain drive) |
| checksum_ok_o | output | 1 | Stored checksum matches the computed one |

## Verification
On every cycle, the assertions check the following:
- The data-line drive never changes while the synchronised clock is high.
- The block never drives the line when it is idle.
- The first and last locked bytes never change.
- The checksum status never claims a match while a recomputation is still running.

Only the bench scenarios can show the other behaviours:
- that the address match follows the straps;
- that the table values read back correctly;
- that pointer wrap works on both reads and writes;
- that a NACK releases the bus;
- that status drops and recovers after a write.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AACK,
    ST_WADDR,
    ST_WACK,
    ST_WDATA,
    ST_RDATA,
    ST_MACK
  } spd_state_e;

  // Factory configuration table; unlisted bytes are zero.
  function automatic logic [7:0] spd_default(input int idx);
    logic [7:0] v;
    case (idx)
      0:  v = 8'h80;  1:  v = 8'h08;  2:  v = 8'h04;  3:  v = 8'h0B;
      4:  v = 8'h09;  5:  v = 8'h01;  6:  v = 8'h40;  7:  v = 8'h00;
      8:  v = 8'h01;  9:  v = 8'hA0;  10: v = 8'h75;  11: v = 8'h00;
      12: v = 8'h80;  13: v = 8'h08;  14: v = 8'h00;  15: v = 8'h01;
      16: v = 8'h0F;  17: v = 8'h02;  18: v = 8'h06;  19: v = 8'h01;
      20: v = 8'h01;  21: v = 8'h00;  22: v = 8'h0E;  23: v = 8'hF0;
      24: v = 8'h80;  27: v = 8'h1E;  28: v = 8'h14;  29: v = 8'h1E;
      30: v = 8'h32;  31: v = 8'h04;  62: v = 8'h01;  63: v = 8'h9E;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/spd_bus_sync.sv
module spd_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/spd_store.sv
module spd_store #(
  parameter int DEPTH   = 256,
  parameter int LOCKED  = 128,
  parameter int CSUM_AT = 63,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  output logic          scan_busy,
  output logic          csum_ok
);
  localparam logic [AW-1:0] LOCK_LIM = AW'(LOCKED);
  localparam logic [AW-1:0] SUM_LAST = AW'(CSUM_AT - 1);
  localparam logic [AW-1:0] SUM_POS  = AW'(CSUM_AT);

  logic [7:0]    cells [DEPTH];
  logic [AW-1:0] scan_idx;
  logic [7:0]    acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= spd_pkg::spd_default(i);
    end else if (we && waddr >= LOCK_LIM) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];

  // Serial recomputation: one byte per clock over 0..CSUM_AT-1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_busy <= 1'b1;
      scan_idx  <= '0;
      acc       <= '0;
      csum_ok   <= 1'b0;
    end else if (we) begin
      scan_busy <= 1'b1;
      scan_idx  <= '0;
      acc       <= '0;
      csum_ok   <= 1'b0;
    end else if (scan_busy) begin
      acc      <= acc + cells[scan_idx];
      scan_idx <= scan_idx + 1'b1;
      if (scan_idx == SUM_LAST) begin
        scan_busy <= 1'b0;
        csum_ok   <= ((acc + cells[scan_idx]) == cells[SUM_POS]);
      end
    end
  end
endmodule

// File: rtl/spd_rom.sv
module spd_rom #(
  parameter int         MEM_BYTES    = 256,
  parameter int         LOCKED_BYTES = 128,
  parameter int         CSUM_AT      = 63,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [3:0] DEV_PREFIX   = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       checksum_ok_o
);
  import spd_pkg::*;
  localparam int AW = $clog2(MEM_BYTES);
  localparam int BW = 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  spd_state_e    state;
  logic [3:0]    bit_cnt;
  logic [BW-1:0] shreg, txsr;
  logic [AW-1:0] ptr, wr_addr;
  logic [BW-1:0] wr_data, rd_data;
  logic          mem_we, rd_mode, m_nack, scan_busy;
  logic          bus_idle;

  spd_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  spd_store #(.DEPTH(MEM_BYTES), .LOCKED(LOCKED_BYTES), .CSUM_AT(CSUM_AT)) u_store (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(ptr), .rdata(rd_data), .scan_busy(scan_busy), .csum_ok(checksum_ok_o)
  );

  assign bus_idle = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      txsr     <= '0;
      ptr      <= '0;
      wr_addr  <= '0;
      wr_data  <= '0;
      mem_we   <= 1'b0;
      rd_mode  <= 1'b0;
      m_nack   <= 1'b1;
      sda_oe_o <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (stop_det) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_det) begin
        state    <= ST_DEV;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              shreg   <= {shreg[BW-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (state == ST_DEV) begin
                if (shreg[7:1] == {DEV_PREFIX, strap_i}) begin
                  sda_oe_o <= 1'b1;
                  rd_mode  <= shreg[0];
                  state    <= ST_AACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_WADDR) begin
                ptr      <= shreg;
                sda_oe_o <= 1'b1;
                state    <= ST_WACK;
              end else begin
                mem_we   <= 1'b1;
                wr_addr  <= ptr;
                wr_data  <= shreg;
                ptr      <= ptr + 1'b1;
                sda_oe_o <= 1'b1;
                state    <= ST_WACK;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rd_mode) begin
                txsr     <= rd_data;
                sda_oe_o <= ~rd_data[BW-1];
                state    <= ST_RDATA;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= ST_WADDR;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              state    <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe_o <= 1'b0;
                ptr      <= ptr + 1'b1;
                bit_cnt  <= '0;
                state    <= ST_MACK;
              end else begin
                txsr     <= {txsr[BW-2:0], 1'b0};
                sda_oe_o <= ~txsr[BW-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              m_nack <= sda_s;
            end else if (scl_fall) begin
              if (!m_nack) begin
                txsr     <= rd_data;
                sda_oe_o <= ~rd_data[BW-1];
                bit_cnt  <= '0;
                state    <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spd_rom_chk.sv
module spd_rom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       bus_idle,
  input logic       csum_ok,
  input logic       scan_busy,
  input logic [7:0] lock_first,
  input logic [7:0] lock_last
);
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !sda_oe); // R2
  AST_LOCK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(lock_first)); // R4
  AST_LOCK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(lock_last)); // R4
  AST_CSUM_AFTER_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    csum_ok |-> !scan_busy); // R8
endmodule

bind spd_rom spd_rom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(u_sync.scl_s), .sda_oe(sda_oe_o),
  .bus_idle(bus_idle), .csum_ok(checksum_ok_o), .scan_busy(u_store.scan_busy),
  .lock_first(u_store.cells[0]), .lock_last(u_store.cells[LOCKED_BYTES-1])
);

// File: tb/spd_rom_tb_top.sv
module spd_rom_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};
  // {word address, expected byte}
  localparam logic [15:0] VEC [12] = '{
    16'h00_80, 16'h01_08, 16'h02_04, 16'h03_0B, 16'h06_40, 16'h09_A0,
    16'h0A_75, 16'h1B_1E, 16'h1C_14, 16'h1D_1E, 16'h1E_32, 16'h3F_9E
  };

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic sda_oe, csum_ok, sda_bus, scl_prev = 1, oe_prev = 0;
  int checks = 0, fails = 0, viol = 0;

  assign sda_bus = sda_m & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  spd_rom dut_i (
    .clk(clk), .rst_n(rst_n), .strap_i(STRAP), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .checksum_ok_o(csum_ok)
  );

  // R9: drive must not change while SCL has been high
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_prev && sda_oe !== oe_prev) viol++;
    scl_prev <= scl_m;
    oe_prev  <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start;
    sda_m = 1; w(Q); scl_m = 1; w(Q); sda_m = 0; w(Q); scl_m = 0; w(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 0; w(Q); scl_m = 1; w(Q); sda_m = 1; w(Q);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q); scl_m = 1; w(Q); scl_m = 0; w(Q);
    end
    sda_m = 1; w(Q); scl_m = 1; w(Q/2); ack = sda_bus; w(Q/2); scl_m = 0; w(Q);
  endtask

  task automatic recv(output logic [7:0] b, input logic nack);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl_m = 1; w(Q/2); b[i] = sda_bus; w(Q/2); scl_m = 0; w(Q);
    end
    sda_m = nack; w(Q); scl_m = 1; w(Q); scl_m = 0; w(Q); sda_m = 1;
  endtask

  task automatic set_ptr_read(input logic [7:0] addr);
    logic a;
    i2c_start; send(DEV_W, a); send(addr, a); i2c_start; send(DEV_R, a);
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    chk("R1 oe in reset", sda_oe, 0);
    w(5); rst_n = 1; w(2);
    chk("R1 oe after reset", sda_oe, 0);
    w(80);
    chk("R1/R8 checksum after reset", csum_ok, 1);

    // table walk: random reads of the factory table
    foreach (VEC[k]) begin
      set_ptr_read(VEC[k][15:8]); recv(b, 1); i2c_stop;
      chk("R5 table byte", b, VEC[k][7:0]);
    end

    // address decode
    i2c_start; send({4'b1010, 3'b000, 1'b0}, a); i2c_stop;
    chk("R2 wrong strap nack", a, 1);
    i2c_start; send({4'b0110, STRAP, 1'b0}, a); i2c_stop;
    chk("R2 wrong prefix nack", a, 1);
    i2c_start; send(DEV_W, a); i2c_stop;
    chk("R2 match ack", a, 0);

    // multi-byte write into user half, then sequential readback
    i2c_start; send(DEV_W, a); send(8'h80, a); send(8'hA5, a); send(8'h3C, a); i2c_stop;
    chk("R3 data ack", a, 0);
    set_ptr_read(8'h80); recv(b, 0);
    chk("R3 readback 80h", b, 8'hA5);
    recv(b, 1); i2c_stop;
    chk("R10/R6 next byte 81h", b, 8'h3C);

    // locked region write
    w(100);
    i2c_start; send(DEV_W, a); send(8'h05, a); send(8'hFF, a);
    chk("R4 locked write acked", a, 0);
    chk("R8 status low during recompute", csum_ok, 0);
    i2c_stop; w(100);
    chk("R8 status restored", csum_ok, 1);
    set_ptr_read(8'h05); recv(b, 1); i2c_stop;
    chk("R4 locked byte unchanged", b, 8'h01);

    // wrap on write then read
    i2c_start; send(DEV_W, a); send(8'hFF, a); send(8'h77, a); send(8'h55, a); i2c_stop;
    set_ptr_read(8'hFE); recv(b, 0);
    chk("R6 byte FEh", b, 8'h00);
    recv(b, 0);
    chk("R10 byte FFh", b, 8'h77);
    recv(b, 1);
    chk("R6 wrap to byte 0", b, 8'h80);
    chk("R7 released after nack", sda_oe, 0);
    i2c_stop;
    i2c_start; send(DEV_R, a); recv(b, 1); i2c_stop;
    chk("R7 next transfer acked", a, 0);
    chk("R7 pointer continues at 1", b, 8'h08);

    chk("R9 no drive change while SCL high", viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule